// File: doc/BRIEF.md
# Multi-Port Receive DMA Engine

This block drains received frame words from several per-port receive FIFOs into a shared frame buffer memory over a single 64-bit write bus. Each FIFO presents one 8-byte word at a time, together with a valid byte count, an end-of-frame marker and an error marker. The engine serves the ports in rotating turns. A turn moves one word, which may be shorter than 8 bytes when the frame ends inside it. A port whose FIFO is empty gives up its turn without costing a cycle.

Every frame lands in a buffer chosen by a handle that the buffer manager offers on a per-port input. The handle is taken when the frame's first word is moved. The write address is the buffer's base plus the frame's running byte offset, and that offset starts again at zero for every new frame. While words pass by, the engine keeps a copy of the first 64 bytes of the frame.

When the final word arrives with a good status, the engine raises a forwarding lookup request with a valid/ready handshake. The request carries the port, the handle, the frame length and the captured leading bytes, which hold both MAC addresses. Several ports can have requests waiting at the same time, and the engine grants them in rotation. A frame that ends with an error produces no request, and its handle is handed back for reuse.

Top module: `rxdma_engine`

## Requirements
- R1: A word is popped from at most one port per cycle, and only from a port whose `rx_valid` is high. The popped word appears on the memory bus one cycle later (`mem_we`=1) with identical data.
- R2: Turns rotate. After port p is served, the next port served is the first eligible port after p in increasing index order, wrapping around. Eligible means `rx_valid`=1 and no request pending for that port. Ineligible ports are skipped in the same cycle. After reset the rotation starts at port 0.
- R3: The write address is `buf_handle * 2**BUF_SHIFT + 8*k`, where k is the word's index within its frame (0 for the first word). The handle is sampled from the port's `buf_handle` in the cycle the frame's first word is popped.
- R4: `mem_nbytes` is 8 for words that are not the last word of a frame. The last word carries the FIFO's count, a value from 1 to 8.
- R5: A request for a frame is raised only after its last word (`rx_eof`=1 with `rx_err`=0) has been written. `req_len` = 8*(words-1) + count of the last word.
- R6: `req_hdr` word k, at bits [64k+63:64k], holds the frame's word k for k below the frame's word count, and holds zero otherwise. `req_handle` is the frame's handle and `req_port` is its port.
- R7: A frame whose last word has `rx_err`=1 never produces a request. Instead, `free_valid` pulses for one cycle with `free_handle` equal to the frame's handle, in the same cycle as that word's memory write. In every other cycle `free_valid` is 0.
- R8: While a port has a request pending, no word is popped from that port.
- R9: Pending requests are granted in rotation: after port q is accepted, the next request offered is from the first pending port after q. While `req_valid`=1 and `req_ready`=0, the request stays valid and `req_port`, `req_handle`, `req_len` and `req_hdr` hold steady.
- R10: During reset `mem_we`, `req_valid` and `free_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | NUM_PORTS | FIFO of each port holds a word |
| rx_pop | output | NUM_PORTS | Removes the presented word from that port's FIFO |
| rx_data | input | NUM_PORTS x 64 | Word presented by each FIFO |
| rx_nbytes | input | NUM_PORTS x 4 | Valid bytes in the presented word (1..8) |
| rx_eof | input | NUM_PORTS | Presented word ends the frame |
| rx_err | input | NUM_PORTS | Frame ended badly (valid with rx_eof) |
| buf_handle | input | NUM_PORTS x HANDLE_W | Buffer handle offered for the port's next frame |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | 64 | Write data |
| mem_nbytes | output | 4 | Valid bytes in the write |
| req_valid | output | 1 | Lookup request offered |
| req_ready | input | 1 | Lookup request accepted |
| req_port | output | PORT_W | Port the frame arrived on |
| req_handle | output | HANDLE_W | Buffer handle of the frame |
| req_len | output | BUF_SHIFT | Frame length in bytes |
| req_hdr | output | HDR_WORDS x 64 | First bytes of the frame |
| free_valid | output | 1 | Handle return strobe for a bad frame |
| free_handle | output | HANDLE_W | Returned handle |

## Verification
The bench first runs four ports with long frames at once, which separates true rotation from a fixed-priority scan. It then runs only the odd ports, so a scheduler that wastes cycles on empty ports shows up as a gap in the writes. A sweep of frame lengths follows, covering 1, 7, 8, 9, 63, 64, 65 bytes and longer. Those lengths show the partial-word byte counts and the boundary where the header buffer fills and then stops copying. Some of these frames end with an error and must come back as freed handles instead of requests. During the sweep the request acceptor toggles, which tests the hold rule. A last phase withholds acceptance while every port completes a frame: it checks that no port with a waiting request is popped, and that the requests are then granted in rotation.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int DATA_W = 64;
    localparam int CNT_W  = 4;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  nbytes;
        logic              eof;
        logic              err;
    } rx_word_t;

    function automatic int unsigned wrap_next(int unsigned idx, int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/rxdma_rr_arbiter.sv
module rxdma_rr_arbiter #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    input  logic             advance,
    input  logic [IDX_W-1:0] taken,
    output logic [IDX_W-1:0] gnt_idx,
    output logic             any
);
    logic [IDX_W-1:0] ptr;

    always_comb begin
        logic [IDX_W:0] sum;
        any     = 1'b0;
        gnt_idx = '0;
        sum     = '0;
        for (int i = 0; i < N; i++) begin
            sum = {1'b0, ptr} + (IDX_W+1)'(i);
            if (sum >= (IDX_W+1)'(N)) sum = sum - (IDX_W+1)'(N);
            if (!any && req[sum[IDX_W-1:0]]) begin
                any     = 1'b1;
                gnt_idx = sum[IDX_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else if (advance) ptr <= IDX_W'(rxdma_pkg::wrap_next(32'(taken), N));
    end

    AST_TAKEN_WAS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        advance |-> req[taken]); // R2

endmodule

// File: rtl/rxdma_port_ctx.sv
module rxdma_port_ctx
    import rxdma_pkg::*;
#(
    parameter int HANDLE_W  = 4,
    parameter int WIDX_W    = 8,
    parameter int HDR_WORDS = 8,
    localparam int LEN_W    = WIDX_W + 3
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           take,
    input  rx_word_t                       word,
    input  logic [HANDLE_W-1:0]            handle_in,
    input  logic                           accept,
    output logic                           pending,
    output logic [HANDLE_W-1:0]            frame_handle,
    output logic [HANDLE_W-1:0]            held_handle,
    output logic [WIDX_W-1:0]              widx,
    output logic [LEN_W-1:0]               len,
    output logic [HDR_WORDS-1:0][DATA_W-1:0] hdr
);
    logic first;

    assign first        = (widx == '0);
    assign frame_handle = first ? handle_in : held_handle;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending     <= 1'b0;
            held_handle <= '0;
            widx        <= '0;
            len         <= '0;
            hdr         <= '0;
        end else begin
            if (accept) pending <= 1'b0;
            if (take) begin
                if (first) held_handle <= handle_in;
                for (int k = 0; k < HDR_WORDS; k++) begin
                    if (first)
                        hdr[k] <= (k == 0) ? word.data : '0;
                    else if (widx == WIDX_W'(k))
                        hdr[k] <= word.data;
                end
                if (word.eof) begin
                    widx <= '0;
                    if (!word.err) begin
                        pending <= 1'b1;
                        len     <= {widx, 3'b000} + LEN_W'(word.nbytes);
                    end
                end else begin
                    widx <= widx + 1'b1;
                end
            end
        end
    end

    AST_NO_POP_WHILE_PENDING: assert property (@(posedge clk) disable iff (rst)
        take |-> !pending); // R8
    AST_GOOD_END_RAISES: assert property (@(posedge clk) disable iff (rst)
        take && word.eof && !word.err |=> pending); // R5
    AST_BAD_END_SILENT: assert property (@(posedge clk) disable iff (rst)
        take && word.eof && word.err |=> !pending); // R7
    AST_ACCEPT_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
        accept |-> pending); // R9

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int HANDLE_W  = 4,
    parameter int BUF_SHIFT = 11,
    parameter int ADDR_W    = 16,
    parameter int HDR_WORDS = 8,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int WIDX_W   = BUF_SHIFT - 3,
    localparam int LEN_W    = BUF_SHIFT
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NUM_PORTS-1:0]                  rx_valid,
    output logic [NUM_PORTS-1:0]                  rx_pop,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]      rx_data,
    input  logic [NUM_PORTS-1:0][CNT_W-1:0]       rx_nbytes,
    input  logic [NUM_PORTS-1:0]                  rx_eof,
    input  logic [NUM_PORTS-1:0]                  rx_err,
    input  logic [NUM_PORTS-1:0][HANDLE_W-1:0]    buf_handle,
    output logic                                  mem_we,
    output logic [ADDR_W-1:0]                     mem_addr,
    output logic [DATA_W-1:0]                     mem_data,
    output logic [CNT_W-1:0]                      mem_nbytes,
    output logic                                  req_valid,
    input  logic                                  req_ready,
    output logic [PORT_W-1:0]                     req_port,
    output logic [HANDLE_W-1:0]                   req_handle,
    output logic [LEN_W-1:0]                      req_len,
    output logic [HDR_WORDS-1:0][DATA_W-1:0]      req_hdr,
    output logic                                  free_valid,
    output logic [HANDLE_W-1:0]                   free_handle
);
    rx_word_t                              words   [NUM_PORTS];
    logic [NUM_PORTS-1:0]                  pend;
    logic [NUM_PORTS-1:0]                  eligible;
    logic [NUM_PORTS-1:0]                  accept;
    logic [HANDLE_W-1:0]                   fh      [NUM_PORTS];
    logic [HANDLE_W-1:0]                   hh      [NUM_PORTS];
    logic [WIDX_W-1:0]                     widx_a  [NUM_PORTS];
    logic [LEN_W-1:0]                      len_a   [NUM_PORTS];
    logic [HDR_WORDS-1:0][DATA_W-1:0]      hdr_a   [NUM_PORTS];

    logic [PORT_W-1:0] s_idx, r_idx, hold_port;
    logic              s_any, r_any, hold_q, req_fire;
    rx_word_t          sel_word;

    // per-port frame context
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign words[p] = '{data: rx_data[p], nbytes: rx_nbytes[p],
                            eof: rx_eof[p], err: rx_err[p]};
        assign eligible[p] = rx_valid[p] & ~pend[p];
        assign accept[p]   = req_fire && (req_port == PORT_W'(p));

        rxdma_port_ctx #(
            .HANDLE_W (HANDLE_W),
            .WIDX_W   (WIDX_W),
            .HDR_WORDS(HDR_WORDS)
        ) u_ctx (
            .clk         (clk),
            .rst         (rst),
            .take        (rx_pop[p]),
            .word        (words[p]),
            .handle_in   (buf_handle[p]),
            .accept      (accept[p]),
            .pending     (pend[p]),
            .frame_handle(fh[p]),
            .held_handle (hh[p]),
            .widx        (widx_a[p]),
            .len         (len_a[p]),
            .hdr         (hdr_a[p])
        );
    end

    // transfer turns
    rxdma_rr_arbiter #(.N(NUM_PORTS)) u_turns (
        .clk    (clk),
        .rst    (rst),
        .req    (eligible),
        .advance(s_any),
        .taken  (s_idx),
        .gnt_idx(s_idx),
        .any    (s_any)
    );

    always_comb begin
        rx_pop = '0;
        if (s_any) rx_pop[s_idx] = 1'b1;
    end

    assign sel_word = words[s_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we      <= 1'b0;
            mem_addr    <= '0;
            mem_data    <= '0;
            mem_nbytes  <= '0;
            free_valid  <= 1'b0;
            free_handle <= '0;
        end else begin
            mem_we      <= s_any;
            mem_addr    <= (ADDR_W'(fh[s_idx]) << BUF_SHIFT)
                           + ADDR_W'({widx_a[s_idx], 3'b000});
            mem_data    <= sel_word.data;
            mem_nbytes  <= sel_word.nbytes;
            free_valid  <= s_any & sel_word.eof & sel_word.err;
            free_handle <= fh[s_idx];
        end
    end

    // lookup request arbitration
    assign req_fire = req_valid & req_ready;

    rxdma_rr_arbiter #(.N(NUM_PORTS)) u_reqs (
        .clk    (clk),
        .rst    (rst),
        .req    (pend),
        .advance(req_fire),
        .taken  (req_port),
        .gnt_idx(r_idx),
        .any    (r_any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= 1'b0;
            hold_port <= '0;
        end else begin
            hold_q    <= req_valid & ~req_ready;
            hold_port <= req_port;
        end
    end

    assign req_valid  = r_any;
    assign req_port   = hold_q ? hold_port : r_idx;
    assign req_handle = hh[req_port];
    assign req_len    = len_a[req_port];
    assign req_hdr    = hdr_a[req_port];

    AST_POP_ONLY_VALID: assert property (@(posedge clk) disable iff (rst)
        (rx_pop & ~rx_valid) == '0); // R1
    AST_WRITE_FOLLOWS_POP: assert property (@(posedge clk) disable iff (rst)
        (|rx_pop) |=> mem_we); // R1
    AST_NBYTES_RANGE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_nbytes >= CNT_W'(1) && mem_nbytes <= CNT_W'(8))); // R4
    AST_FREE_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
        free_valid |-> mem_we); // R7
    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_port)
            && $stable(req_handle) && $stable(req_len) && $stable(req_hdr)); // R9

endmodule

// File: tb/rxdma_engine_test.sv
`timescale 1ns/1ps
module rxdma_engine_test;
    localparam int NP = 4;
    localparam int MAXF = 16;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [NP-1:0]            rx_valid, rx_pop, rx_eof, rx_err;
    logic [NP-1:0][63:0]      rx_data;
    logic [NP-1:0][3:0]       rx_nbytes;
    logic [NP-1:0][3:0]       buf_handle;
    logic                     mem_we, req_valid, req_ready, free_valid;
    logic [15:0]              mem_addr;
    logic [63:0]              mem_data;
    logic [3:0]               mem_nbytes, req_handle, free_handle;
    logic [1:0]               req_port;
    logic [10:0]              req_len;
    logic [7:0][63:0]         req_hdr;

    rxdma_engine uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_nbytes(rx_nbytes), .rx_eof(rx_eof), .rx_err(rx_err),
        .buf_handle(buf_handle), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_nbytes(mem_nbytes), .req_valid(req_valid),
        .req_ready(req_ready), .req_port(req_port), .req_handle(req_handle),
        .req_len(req_len), .req_hdr(req_hdr), .free_valid(free_valid),
        .free_handle(free_handle)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    int lens [NP][MAXF];
    bit errs [NP][MAXF];
    int nfr  [NP];
    bit en   [NP];
    int cf   [NP];
    int cw   [NP];

    function automatic logic [63:0] wdata(int p, int f, int w);
        return {8'(p), 8'h5C, 8'(f), 8'(w), 32'(f*7919 + w*131 + p*17) ^ 32'hC3A51E0F};
    endfunction

    function automatic logic [3:0] hnd(int p, int f);
        return 4'((p*5 + f*3) & 15);
    endfunction

    function automatic int nwords(int len);
        return (len + 7) / 8;
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // FIFO model
    always_comb begin
        for (int p = 0; p < NP; p++) begin
            automatic bit v = en[p] && (cf[p] < nfr[p]);
            automatic int fi = (cf[p] < MAXF) ? cf[p] : 0;
            automatic int nw = nwords(lens[p][fi]);
            automatic bit last = (cw[p] == nw - 1);
            rx_valid[p]   = v;
            rx_data[p]    = v ? wdata(p, cf[p], cw[p]) : 64'd0;
            rx_eof[p]     = v && last;
            rx_err[p]     = v && last && errs[p][fi];
            rx_nbytes[p]  = !v ? 4'd0 : last ? 4'(lens[p][fi] - 8*(nw-1)) : 4'd8;
            buf_handle[p] = hnd(p, cf[p]);
        end
    end

    always @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (rst) begin
                cf[p] <= 0;
                cw[p] <= 0;
            end else if (rx_pop[p]) begin
                if (rx_eof[p]) begin
                    cf[p] <= cf[p] + 1;
                    cw[p] <= 0;
                end else begin
                    cw[p] <= cw[p] + 1;
                end
            end
        end
    end

    // monitor state
    int mon_f [NP];
    int wcnt  [NP];
    bit waiting [NP];
    int wait_f [NP];
    logic [NP-1:0] exp_elig = '0;
    int last_port = NP-1;
    int last_acc  = NP-1;
    bit prev_hold = 0;
    int nreq = 0;
    int nfree = 0;

    task automatic monitor();
        forever begin
            @(negedge clk);
            // memory write side
            if (exp_elig != 0) begin
                int ep = -1;
                for (int i = 1; i <= NP; i++) begin
                    int c = (last_port + i) % NP;
                    if (ep < 0 && exp_elig[c]) ep = c;
                end
                chk(mem_we && mem_data[63:56] == 8'(ep), "R2", "served port",
                    {63'd0, mem_we} << 8 | 64'(mem_data[63:56]), 64'(ep) | 64'h100);
                begin
                    int f = mon_f[ep];
                    int w = wcnt[ep];
                    int nw = nwords(lens[ep][f]);
                    bit last = (w == nw - 1);
                    chk(mem_data == wdata(ep, f, w), "R1", "write data", mem_data, wdata(ep, f, w));
                    chk(mem_addr == 16'((int'(hnd(ep, f)) << 11) + w*8), "R3", "write address",
                        64'(mem_addr), 64'((int'(hnd(ep, f)) << 11) + w*8));
                    chk(mem_nbytes == (last ? 4'(lens[ep][f] - 8*(nw-1)) : 4'd8), "R4", "byte count",
                        64'(mem_nbytes), 64'(last ? lens[ep][f] - 8*(nw-1) : 8));
                    if (last) begin
                        if (errs[ep][f]) begin
                            chk(free_valid && free_handle == hnd(ep, f), "R7", "handle return",
                                {59'd0, free_valid, free_handle}, {59'd1, hnd(ep, f)});
                            nfree++;
                        end else begin
                            chk(!free_valid, "R7", "no return on good end", 64'(free_valid), 64'd0);
                            waiting[ep] = 1;
                            wait_f[ep]  = f;
                        end
                        mon_f[ep]++;
                        wcnt[ep] = 0;
                    end else begin
                        chk(!free_valid, "R7", "no return mid frame", 64'(free_valid), 64'd0);
                        wcnt[ep]++;
                    end
                end
                last_port = ep;
            end else begin
                chk(!mem_we && !free_valid, "R2", "idle bus when nothing eligible",
                    {62'd0, mem_we, free_valid}, 64'd0);
            end
            // what the scheduler may pick at the coming edge
            for (int p = 0; p < NP; p++) exp_elig[p] = rx_valid[p] && !waiting[p];
            // request side
            if (req_valid) begin
                int q = int'(req_port);
                chk(waiting[q], "R5", "request only after good end", 64'(waiting[q]), 64'd1);
                if (req_ready && waiting[q]) begin
                    int f = wait_f[q];
                    int nw = nwords(lens[q][f]);
                    if (!prev_hold) begin
                        int ea = -1;
                        for (int i = 1; i <= NP; i++) begin
                            int c = (last_acc + i) % NP;
                            if (ea < 0 && waiting[c]) ea = c;
                        end
                        chk(q == ea, "R9", "request grant order", 64'(q), 64'(ea));
                    end
                    chk(req_handle == hnd(q, f), "R6", "request handle", 64'(req_handle), 64'(hnd(q, f)));
                    chk(req_len == 11'(lens[q][f]), "R5", "request length", 64'(req_len), 64'(lens[q][f]));
                    for (int k = 0; k < 8; k++) begin
                        logic [63:0] e = (k < nw) ? wdata(q, f, k) : 64'd0;
                        chk(req_hdr[k] == e, "R6", $sformatf("header word %0d", k), req_hdr[k], e);
                    end
                    waiting[q] = 0;
                    last_acc = q;
                    nreq++;
                end
            end
            prev_hold = req_valid && !req_ready;
        end
    endtask

    task automatic add_frame(int p, int len, bit bad);
        lens[p][nfr[p]] = len;
        errs[p][nfr[p]] = bad;
        nfr[p]++;
    endtask

    task automatic drain();
        int guard = 0;
        bit done = 0;
        while (!done && guard < 4000) begin
            @(posedge clk); #1;
            done = !req_valid;
            for (int p = 0; p < NP; p++)
                if (cf[p] != nfr[p] || mon_f[p] != nfr[p] || waiting[p]) done = 0;
            guard++;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int sweep [16] = '{1, 8, 9, 64, 65, 13, 72, 7, 56, 57, 120, 16, 63, 2, 71, 33};
        int good = 0;
        int bad = 0;
        for (int p = 0; p < NP; p++) begin
            nfr[p] = 0; en[p] = 0; mon_f[p] = 0; wcnt[p] = 0; waiting[p] = 0; wait_f[p] = 0;
            for (int f = 0; f < MAXF; f++) begin lens[p][f] = 8; errs[p][f] = 0; end
        end
        req_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!mem_we && !req_valid && !free_valid, "R10", "reset outputs",
            {61'd0, mem_we, req_valid, free_valid}, 64'd0);
        @(posedge clk); #1;
        rst = 1'b0;
        fork monitor(); join_none

        // phase 1: all ports, long frames, rotation from port 0
        for (int p = 0; p < NP; p++) begin add_frame(p, 160, 0); en[p] = 1; end
        drain();

        // phase 2: odd ports only, empty ports skipped
        for (int p = 0; p < NP; p++) en[p] = (p % 2 == 1);
        add_frame(1, 8, 0); add_frame(1, 9, 0); add_frame(1, 80, 0);
        add_frame(3, 80, 0); add_frame(3, 9, 1); add_frame(3, 8, 0);
        drain();

        // phase 3: length sweep with bad ends and a toggling acceptor
        for (int p = 0; p < NP; p++) begin
            en[p] = 1;
            for (int f = 0; f < 4; f++) add_frame(p, sweep[(p*4+f) % 16], ((p*4+f) % 5) == 3);
        end
        for (int k = 0; k < 400; k++) begin
            @(posedge clk); #1;
            req_ready = (k % 3) != 1;
        end
        req_ready = 1'b1;
        drain();

        // phase 4: acceptor stalled while every port completes a frame
        req_ready = 1'b0;
        for (int p = 0; p < NP; p++) begin
            add_frame(p, 8*(p+1) - p, 0);
            add_frame(p, 12, 0);
        end
        repeat (60) @(posedge clk);
        @(negedge clk);
        chk(req_valid && rx_valid == 4'hF && rx_pop == 4'h0, "R8", "no pop while request waits",
            {59'd0, req_valid, rx_valid, rx_pop}, {59'd1, 4'hF, 4'h0});
        @(posedge clk); #1;
        req_ready = 1'b1;
        drain();

        for (int p = 0; p < NP; p++) begin
            chk(mon_f[p] == nfr[p], "R1", $sformatf("frames written port %0d", p),
                64'(mon_f[p]), 64'(nfr[p]));
            for (int f = 0; f < nfr[p]; f++) if (errs[p][f]) bad++; else good++;
        end
        chk(nreq == good, "R5", "request count", 64'(nreq), 64'(good));
        chk(nfree == bad, "R7", "returned handle count", 64'(nfree), 64'(bad));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule